// File: doc/BRIEF.md
# Grouped Compacted-Table Test Control Generator

This block drives the control signals of a data path during structural test. The combinational modules of the data path are split into groups, and each group has one compacted table. The table is a short sequence of control-signal values that exercises every module of the group at once. Each table entry is either a constant or a bit taken from a small pattern register. The pattern register is filled from primary inputs and holds the part of the test pattern that changes from one application to the next.

A sequencer outside the block selects a group and pulses `start`. The block then applies that group's table as many times as the largest pattern count among the group's modules. Each application is one load cycle followed by the table's steps. When the last application is done, the block raises `done` for one cycle so that the sequencer can move on to the next group.

One step counter is shared by all groups, and it wraps at the length of the selected group. Each group has its own decoder. A multiplexer array passes the selected group's decoder outputs onto the control vector and forces to zero every control signal that the group does not drive. Table contents, drive masks, lengths and repetition counts are all parameters.

Top module: `gtcg_top`

## Requirements
- R1: While `rst` is high and after its release, `ctrl` and `done` are 0 and the block is idle until a start is accepted.
- R2: A `start` seen while idle with `test_en` high latches `grp_sel` as the active group. The next cycle is a load cycle. Every application of the table is one load cycle plus one cycle per table step, and `ctrl` is 0 for the load cycle.
- R3: For step s of group g, control bit k is either a constant or a pattern bit, as set by the table. The constant is table bit `TBL_VAL[(g*MAX_LEN+s)*NUM_CTRL+k]`. The pattern bit is selected when `TBL_PSEL` has the same bit set, and it is pattern register bit `k % PAT_W`. The value appears on `ctrl` one clock after the step is active (registered output).
- R4: A control bit whose bit in the active group's `DRIVE_MASK[g*NUM_CTRL+k]` is 0 is always 0, whatever the table holds.
- R5: The step counter wraps at the active group's own length, so table rows at or beyond that length never appear on `ctrl`.
- R6: In the load cycle the pattern register captures `pi[PAT_W-1:0]` whatever the value of `reload`.
- R7: In a step cycle the pattern register recaptures `pi[PAT_W-1:0]` when `reload` is 1 and holds when `reload` is 0. The step that coincides with a recapture still uses the old value.
- R8: The table is applied `GRP_REPS[g]` times. `done` is high for exactly one cycle, in the same cycle as the last step's output, and the block is idle afterwards.
- R9: From the accepted start to `done`, a group takes `GRP_REPS[g]*(GRP_LEN[g]+1)` cycles. With the default tables (lengths 4 and 3, counts 8 and 3) the two groups take 52 cycles in total.
- R10: While `test_en` is low, `ctrl` and `done` are 0 on the following cycle and `start` is ignored. Dropping `test_en` during a run aborts it to idle.
- R11: While a run is in progress, `start` and `grp_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Test mode enable; low forces outputs to 0 and idles the block |
| reload | input | 1 | Recapture the pattern register during step cycles |
| start | input | 1 | Begin applying the selected group's table |
| grp_sel | input | GW | Group to run, latched on an accepted start |
| pi | input | PI_W | Primary inputs; low PAT_W bits feed the pattern register |
| ctrl | output | NUM_CTRL | Registered control-signal vector |
| done | output | 1 | One-cycle pulse after the group's last application |

## Verification
Two functions can share a cycle. The first is a pattern recapture: a step cycle with `reload` high also decodes a table entry that reads the pattern register. The bench holds `reload` high, or toggles it, while `pi` changes every cycle, and expects the old pattern bit in that step's output and the new one in the following step. The second is the end-of-group pulse, which shares its cycle with the last step's control value; both are compared in the same scoreboard item, and the next item must show the block idle.

// File: rtl/gtcg_pkg.sv
`timescale 1ns/1ps
package gtcg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_STEP = 2'd2
  } phase_t;
endpackage

// File: rtl/gtcg_step_fsm.sv
`timescale 1ns/1ps
// Shared step sequencer: load cycle, table steps, repetitions per group.
module gtcg_step_fsm
  import gtcg_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int LEN_W      = 3,
  parameter int REP_W      = 8,
  parameter int GW         = 1,
  parameter logic [NUM_GROUPS*LEN_W-1:0] GRP_LEN  = '0,
  parameter logic [NUM_GROUPS*REP_W-1:0] GRP_REPS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  logic             start,
  input  logic [GW-1:0]    grp_sel,
  output phase_t           phase_q,
  output logic [LEN_W-1:0] step_q,
  output logic [GW-1:0]    grp_q,
  output logic [LEN_W-1:0] cur_len,
  output logic             last_step
);
  logic [REP_W-1:0] rep_q;
  logic [REP_W-1:0] cur_reps;
  logic             end_of_table;
  logic             end_of_reps;

  assign cur_len      = GRP_LEN[int'(grp_q)*LEN_W +: LEN_W];
  assign cur_reps     = GRP_REPS[int'(grp_q)*REP_W +: REP_W];
  assign end_of_table = (step_q == cur_len - 1'b1);
  assign end_of_reps  = (rep_q == cur_reps - 1'b1);
  assign last_step    = (phase_q == PH_STEP) && end_of_table && end_of_reps;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rep_q   <= '0;
      grp_q   <= '0;
    end else if (!test_en) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rep_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            grp_q   <= grp_sel;
            rep_q   <= '0;
            phase_q <= PH_LOAD;
          end
        end
        PH_LOAD: begin
          step_q  <= '0;
          phase_q <= PH_STEP;
        end
        PH_STEP: begin
          if (end_of_table) begin
            step_q <= '0;
            if (end_of_reps) begin
              rep_q   <= '0;
              phase_q <= PH_IDLE;
            end else begin
              rep_q   <= rep_q + 1'b1;
              phase_q <= PH_LOAD;
            end
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gtcg_pat_reg.sv
`timescale 1ns/1ps
// Pattern register: captured on load cycles, optionally refreshed on steps.
module gtcg_pat_reg
  import gtcg_pkg::*;
#(
  parameter int PI_W  = 4,
  parameter int PAT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  phase_t           phase,
  input  logic             reload,
  input  logic [PI_W-1:0]  pi,
  output logic [PAT_W-1:0] pat_q
);
  logic capture;
  assign capture = test_en && ((phase == PH_LOAD) || (phase == PH_STEP && reload));

  always_ff @(posedge clk) begin
    if (rst)          pat_q <= '0;
    else if (capture) pat_q <= pi[PAT_W-1:0];
  end
endmodule

// File: rtl/gtcg_grp_decoder.sv
`timescale 1ns/1ps
// Per-group table decoder: drives only the controls in its mask.
module gtcg_grp_decoder #(
  parameter int NUM_CTRL = 4,
  parameter int MAX_LEN  = 4,
  parameter int PAT_W    = 2,
  parameter int LEN_W    = 3,
  parameter int TBL_LEN  = 4,
  parameter logic [NUM_CTRL-1:0]         DRV_MASK = '0,
  parameter logic [MAX_LEN*NUM_CTRL-1:0] VAL      = '0,
  parameter logic [MAX_LEN*NUM_CTRL-1:0] PSEL     = '0
) (
  input  logic [LEN_W-1:0]    step,
  input  logic [PAT_W-1:0]    pat,
  output logic [NUM_CTRL-1:0] dec_o
);
  always_comb begin
    dec_o = '0;
    for (int s = 0; s < MAX_LEN; s++) begin
      if (s < TBL_LEN && int'(step) == s) begin
        for (int k = 0; k < NUM_CTRL; k++) begin
          if (DRV_MASK[k]) begin
            dec_o[k] = PSEL[s*NUM_CTRL+k] ? pat[k % PAT_W] : VAL[s*NUM_CTRL+k];
          end
        end
      end
    end
  end
endmodule

// File: rtl/gtcg_ctrl_mux.sv
`timescale 1ns/1ps
// Multiplexer array: routes the active group's decoder onto the controls.
module gtcg_ctrl_mux #(
  parameter int NUM_GROUPS = 2,
  parameter int NUM_CTRL   = 4,
  parameter int GW         = 1,
  parameter logic [NUM_GROUPS*NUM_CTRL-1:0] DRIVE_MASK = '0
) (
  input  logic [NUM_GROUPS*NUM_CTRL-1:0] dec_flat,
  input  logic [GW-1:0]                  grp,
  output logic [NUM_CTRL-1:0]            sel_o
);
  always_comb begin
    sel_o = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(grp) == g) begin
        sel_o = dec_flat[g*NUM_CTRL +: NUM_CTRL] & DRIVE_MASK[g*NUM_CTRL +: NUM_CTRL];
      end
    end
  end
endmodule

// File: rtl/gtcg_top.sv
`timescale 1ns/1ps
// Grouped compacted-table test control generator (top).
module gtcg_top
  import gtcg_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int NUM_CTRL   = 4,
  parameter int MAX_LEN    = 4,
  parameter int PAT_W      = 2,
  parameter int PI_W       = 4,
  parameter int REP_W      = 8,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int GW        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  parameter logic [NUM_GROUPS*LEN_W-1:0]            GRP_LEN    = {3'd3, 3'd4},
  parameter logic [NUM_GROUPS*REP_W-1:0]            GRP_REPS   = {8'd3, 8'd8},
  parameter logic [NUM_GROUPS*NUM_CTRL-1:0]         DRIVE_MASK = 8'hE7,
  parameter logic [NUM_GROUPS*MAX_LEN*NUM_CTRL-1:0] TBL_VAL    = 32'hF34A_6125,
  parameter logic [NUM_GROUPS*MAX_LEN*NUM_CTRL-1:0] TBL_PSEL   = 32'h0280_2410
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                test_en,
  input  logic                reload,
  input  logic                start,
  input  logic [GW-1:0]       grp_sel,
  input  logic [PI_W-1:0]     pi,
  output logic [NUM_CTRL-1:0] ctrl,
  output logic                done
);
  localparam int ROW_BITS = MAX_LEN * NUM_CTRL;

  phase_t                         phase;
  logic [LEN_W-1:0]               step;
  logic [GW-1:0]                  grp;
  logic [LEN_W-1:0]               cur_len;
  logic                           last_step;
  logic [PAT_W-1:0]               pat;
  logic [NUM_GROUPS*NUM_CTRL-1:0] dec_flat;
  logic [NUM_CTRL-1:0]            mux_out;

  gtcg_step_fsm #(
    .NUM_GROUPS(NUM_GROUPS), .LEN_W(LEN_W), .REP_W(REP_W), .GW(GW),
    .GRP_LEN(GRP_LEN), .GRP_REPS(GRP_REPS)
  ) fsm_i (
    .clk(clk), .rst(rst), .test_en(test_en), .start(start), .grp_sel(grp_sel),
    .phase_q(phase), .step_q(step), .grp_q(grp), .cur_len(cur_len),
    .last_step(last_step)
  );

  gtcg_pat_reg #(.PI_W(PI_W), .PAT_W(PAT_W)) pat_i (
    .clk(clk), .rst(rst), .test_en(test_en), .phase(phase),
    .reload(reload), .pi(pi), .pat_q(pat)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    gtcg_grp_decoder #(
      .NUM_CTRL(NUM_CTRL), .MAX_LEN(MAX_LEN), .PAT_W(PAT_W), .LEN_W(LEN_W),
      .TBL_LEN(int'(GRP_LEN[g*LEN_W +: LEN_W])),
      .DRV_MASK(DRIVE_MASK[g*NUM_CTRL +: NUM_CTRL]),
      .VAL(TBL_VAL[g*ROW_BITS +: ROW_BITS]),
      .PSEL(TBL_PSEL[g*ROW_BITS +: ROW_BITS])
    ) dec_i (
      .step(step), .pat(pat), .dec_o(dec_flat[g*NUM_CTRL +: NUM_CTRL])
    );
  end

  gtcg_ctrl_mux #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_CTRL(NUM_CTRL), .GW(GW), .DRIVE_MASK(DRIVE_MASK)
  ) mux_i (
    .dec_flat(dec_flat), .grp(grp), .sel_o(mux_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      done <= 1'b0;
    end else begin
      ctrl <= (test_en && phase == PH_STEP) ? mux_out : '0;
      done <= test_en && last_step;
    end
  end
endmodule

// File: rtl/gtcg_checker.sv
`timescale 1ns/1ps
// Property checker attached to gtcg_top.
module gtcg_checker
  import gtcg_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int NUM_CTRL   = 4,
  parameter int PAT_W      = 2,
  parameter int PI_W       = 4,
  parameter int LEN_W      = 3,
  parameter int GW         = 1,
  parameter logic [NUM_GROUPS*NUM_CTRL-1:0] DRIVE_MASK = '0
) (
  input logic                clk,
  input logic                rst,
  input logic                test_en,
  input logic                reload,
  input logic [PI_W-1:0]     pi,
  input logic [NUM_CTRL-1:0] ctrl,
  input logic                done,
  input phase_t              phase,
  input logic [LEN_W-1:0]    step,
  input logic [GW-1:0]       grp,
  input logic [LEN_W-1:0]    cur_len,
  input logic [PAT_W-1:0]    pat
);
  logic [NUM_CTRL-1:0] act_mask;
  always_comb begin
    act_mask = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (int'(grp) == g) act_mask = DRIVE_MASK[g*NUM_CTRL +: NUM_CTRL];
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (ctrl == '0 && !done))
    else $error("test mode low did not quiet outputs");

  assert_load_blank_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD) |=> (ctrl == '0))
    else $error("control nonzero after load cycle");

  assert_undriven_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl & ~act_mask) == '0)
    else $error("undriven control bit set");

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STEP) |-> (step < cur_len))
    else $error("step beyond group length");

  assert_pat_load_R6: assert property (@(posedge clk) disable iff (rst)
    (test_en && phase == PH_LOAD) |=> (pat == $past(pi[PAT_W-1:0])))
    else $error("pattern not captured in load cycle");

  assert_pat_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (test_en && phase == PH_STEP && !reload) |=> $stable(pat))
    else $error("pattern changed without reload");

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("end pulse longer than one cycle");
endmodule

bind gtcg_top gtcg_checker #(
  .NUM_GROUPS(NUM_GROUPS), .NUM_CTRL(NUM_CTRL), .PAT_W(PAT_W), .PI_W(PI_W),
  .LEN_W(LEN_W), .GW(GW), .DRIVE_MASK(DRIVE_MASK)
) chk_i (
  .clk(clk), .rst(rst), .test_en(test_en), .reload(reload), .pi(pi),
  .ctrl(ctrl), .done(done), .phase(phase), .step(step), .grp(grp),
  .cur_len(cur_len), .pat(pat)
);

// File: tb/gtcg_top_tb_top.sv
`timescale 1ns/1ps
module gtcg_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       test_en = 1'b0;
  logic       reload = 1'b0;
  logic       start = 1'b0;
  logic [0:0] grp_sel = 1'b0;
  logic [3:0] pi = 4'd0;
  logic [3:0] ctrl;
  logic       done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_done_cyc = 0;
  bit finished = 1'b0;

  logic [4:0] q_val[$];
  string      q_tag[$];

  // Independent copy of the default table data from the requirements.
  localparam logic [31:0] E_VAL  = 32'hF34A_6125;
  localparam logic [31:0] E_PSEL = 32'h0280_2410;
  localparam logic [7:0]  E_MASK = 8'hE7;
  localparam int E_LEN[2]  = '{4, 3};
  localparam int E_REPS[2] = '{8, 3};

  always #10 clk = ~clk;

  gtcg_top dut_i (
    .clk(clk), .rst(rst), .test_en(test_en), .reload(reload), .start(start),
    .grp_sel(grp_sel), .pi(pi), .ctrl(ctrl), .done(done)
  );

  function automatic logic [3:0] exp_dec(int g, int s, logic [1:0] p);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int idx = (g*4 + s)*4 + k;
      if (E_MASK[g*4+k]) r[k] = E_PSEL[idx] ? p[k % 2] : E_VAL[idx];
    end
    return r;
  endfunction

  task automatic check(logic [4:0] act, logic [4:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s ctrl/done actual=%b_%b expected=%b_%b",
               tag, act[4:1], act[0], exp[4:1], exp[0]);
    end
  endtask

  task automatic push(logic [3:0] c, logic d, string tag);
    q_val.push_back({c, d});
    q_tag.push_back(tag);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done) last_done_cyc = cyc;
      if (q_val.size() > 0) begin
        logic [4:0] e;
        string t;
        e = q_val.pop_front();
        t = q_tag.pop_front();
        check({ctrl, done}, e, t);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  // rmode: 0 no reload, 1 reload always, 2 reload alternating
  task automatic run_group(int g, int rmode, bit poke, output int meas);
    int len = E_LEN[g];
    int n = E_REPS[g] * (len + 1);
    logic [1:0] patm = 2'b00;
    int start_cyc;
    tick();
    test_en = 1'b1; start = 1'b1; grp_sel = 1'(g); pi = 4'd0; reload = 1'b0;
    start_cyc = cyc + 1;
    push(4'd0, 1'b0, "R2");
    for (int k = 1; k <= n; k++) begin
      int pos = (k - 1) % (len + 1);
      tick();
      start   = poke && (k == 2 || k == len + 3);
      grp_sel = poke ? 1'(1 - g) : 1'(g);
      pi      = 4'((k*7 + g*5 + 3) & 15);
      reload  = (rmode == 1) ? 1'b1 : (rmode == 2) ? 1'(k & 1) : 1'b0;
      if (pos == 0) begin
        patm = pi[1:0];
        push(4'd0, 1'b0, (k == 1) ? "R6" : "R5");
      end else begin
        push(exp_dec(g, pos - 1, patm), (k == n),
             (k == n) ? "R8" : poke ? "R11" : (rmode != 0) ? "R7" : "R3 R4");
        if (reload) patm = pi[1:0];
      end
    end
    tick();
    start = 1'b0; reload = 1'b0; grp_sel = 1'(g);
    push(4'd0, 1'b0, "R8");
    tick();
    meas = last_done_cyc - start_cyc;
  endtask

  initial begin
    int m0, m1, tmp;
    repeat (3) @(posedge clk);
    #1;
    check({ctrl, done}, 5'd0, "R1 in reset");
    tick();
    rst = 1'b0;
    tick();
    check({ctrl, done}, 5'd0, "R1 after release");

    // Start with test mode low is ignored
    for (int i = 0; i < 3; i++) begin
      tick();
      test_en = 1'b0; start = 1'b1; grp_sel = 1'b1; pi = 4'hF;
      push(4'd0, 1'b0, "R10");
    end
    tick();
    start = 1'b0;
    push(4'd0, 1'b0, "R10");

    run_group(0, 0, 1'b0, m0);
    run_group(1, 0, 1'b0, m1);
    check(5'(m0), 5'd0 + 5'(E_REPS[0]*(E_LEN[0]+1)), "R9 group0 length");
    check({1'b0, 4'(m0 + m1 == 52)}, 5'd1, "R9 total 52");

    run_group(0, 1, 1'b1, tmp);
    run_group(1, 2, 1'b0, tmp);

    // Abort by dropping test mode mid-run
    tick();
    test_en = 1'b1; start = 1'b1; grp_sel = 1'b0; pi = 4'd0; reload = 1'b0;
    push(4'd0, 1'b0, "R10");
    tick();
    start = 1'b0; pi = 4'b0110;
    push(4'd0, 1'b0, "R10");
    tick();
    pi = 4'd0;
    push(exp_dec(0, 0, 2'b10), 1'b0, "R3");
    tick();
    test_en = 1'b0;
    push(4'd0, 1'b0, "R10");
    tick();
    test_en = 1'b1;
    push(4'd0, 1'b0, "R10");
    tick();
    push(4'd0, 1'b0, "R10");

    run_group(1, 1, 1'b0, tmp);

    while (q_val.size() > 0) tick();
    tick();
    summary();
  end
endmodule